// File: doc/BRIEF.md
# Ethernet Port Interrupt Status Controller

This block gathers the event pulses that a single-port Ethernet MAC's queue manager produces and latches them into a raw status register. Software reads that register over a simple strobe bus and acknowledges an event by writing a one to its bit. One interrupt line goes out of the block. The line is raised only when a latched event is enabled for its own source and the port-level and global enables are also both on.

The block also tracks how many received frames are waiting to be acknowledged. The single-frame ready bit stays tied to that backlog. Each acknowledge of that bit retires one frame, and the bit comes back one cycle later while frames remain. A coalesced multi-frame ready event is raised either when the backlog reaches a programmable frame threshold or when a programmable timeout runs out after the most recent frame while frames are still pending. Software can enable only the coalesced event, so it takes one interrupt per batch of frames instead of one per frame.

Three word addresses are decoded: status at 0, enable at 1, coalescing at 2. Address 3 reads zero and ignores writes.

Top module: `mac_irq_hub`

## Requirements
- R1: After reset, the status and enable registers read 0, the coalescing register reads 0x08000074 (threshold 8, timeout 0x74), and irq_o is low.
- R2: The status register at address 0 holds four event bits: bit 0 receive frame ready, bit 1 transmit packet done, bit 6 transmit queue empty, bit 7 multiple receive frames ready. An input event pulse sets its bit on the next clock edge. Bits 2 to 5 and 8 to 31 always read 0.
- R3: A write to address 0 clears every status bit whose write-data bit is one and leaves bits written with zero untouched. Writing 0xFF clears all four bits.
- R4: If an event pulse arrives in the same cycle as a write-one clear of its bit, the bit remains set.
- R5: irq_o is high exactly when some status bit and its enable bit in enable[7:0] are both set, enable bit 18 (port enable) is set, and enable bit 19 (global enable) is set.
- R6: Each receive event adds one to a count of pending frames. Each write-one clear of status bit 0 acknowledges one pending frame. Bit 0 reads 0 in the cycle after that clear, and it is set again one cycle later if frames are still pending.
- R7: Status bit 7 is set on the edge at which a receive event raises the pending count to the threshold held in coalescing bits [31:24]. A threshold of 0 turns the count trigger off.
- R8: Every receive event restarts a timer. If frames are still pending, bit 7 is set on the edge T+1 clock edges after the latest receive event, where T is coalescing bits [15:0]. If every frame has been acknowledged before then, bit 7 is not set.
- R9: The enable register reads back only bits [7:0], 18 and 19, with all other bits 0. The coalescing register reads back bits [31:24] and [15:0], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_frame | input | 1 | One-cycle pulse: a received frame is ready |
| ev_tx_done | input | 1 | One-cycle pulse: a transmit packet finished |
| ev_tx_empty | input | 1 | One-cycle pulse: the transmit queue drained |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address: 0 status, 1 enable, 2 coalescing |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest condition to reach is a timer expiry that has been restarted. The check needs a frame pending, no threshold hit, and a second receive event arriving before the first timeout ends. The stimulus programs a short timeout and a threshold of 3. It then places two receive events four cycles apart and samples bit 7 on the edges just before and at the expected firing edge. Ack sequences that drain the backlog before expiry show that the timer stays silent, and back-to-back acks show the one-cycle drop and return of the ready bit.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS   = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_COALESCE = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    localparam int BIT_RX_RDY   = 0;
    localparam int BIT_TX_DONE  = 1;
    localparam int BIT_TX_EMPTY = 6;
    localparam int BIT_RX_MULTI = 7;
    localparam int SRC_W        = 8;
    localparam int EN_PORT_BIT  = 18;
    localparam int EN_GLB_BIT   = 19;
    localparam int THR_LSB      = 24;
    localparam int THR_W        = 8;

    localparam logic [SRC_W-1:0] SRC_MASK = 8'hC3;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             port;
        logic             glb;
    } irq_en_t;
endpackage

// File: rtl/mac_irq_coalesce.sv
module mac_irq_coalesce
    import mac_irq_pkg::*;
#(
    parameter int PCNT_W = 8,
    parameter int TMR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_ev,
    input  logic             rx_ack,
    input  logic [THR_W-1:0] thr,
    input  logic [TMR_W-1:0] tmo,
    output logic             multi_fire,
    output logic             pend_nz
);
    localparam int CW = PCNT_W + 1;
    localparam logic [PCNT_W-1:0] PEND_MAX = {PCNT_W{1'b1}};

    typedef struct packed {
        logic [PCNT_W-1:0] pend;
        logic [TMR_W-1:0]  tmr;
        logic              act;
    } coal_st_t;

    coal_st_t st_d, st_q;
    logic     dec, cnt_fire, tmr_fire;
    logic [CW-1:0] pend_inc;

    always_comb begin
        st_d     = st_q;
        tmr_fire = 1'b0;
        dec      = rx_ack && (st_q.pend != '0);
        pend_inc = CW'(st_q.pend) + CW'(1);
        cnt_fire = rx_ev && !dec && (thr != '0) && (32'(pend_inc) == 32'(thr));

        if (rx_ev && !dec && st_q.pend != PEND_MAX)
            st_d.pend = st_q.pend + PCNT_W'(1);
        else if (dec && !rx_ev)
            st_d.pend = st_q.pend - PCNT_W'(1);

        if (rx_ev) begin
            st_d.tmr = '0;
            st_d.act = 1'b1;
        end else if (st_q.act) begin
            if (st_q.pend == '0) begin
                st_d.act = 1'b0;
            end else if (st_q.tmr == tmo) begin
                tmr_fire = 1'b1;
                st_d.act = 1'b0;
            end else begin
                st_d.tmr = st_q.tmr + TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign multi_fire = cnt_fire || tmr_fire;
    assign pend_nz    = (st_q.pend != '0);

    AST_PEND_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend == PEND_MAX && rx_ev && !rx_ack) |=> (st_q.pend == PEND_MAX)); // R6
    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !rx_ev && st_q.pend != '0) |=> (st_q.pend == $past(st_q.pend) - PCNT_W'(1))); // R6
    AST_TIMER_NEEDS_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend == '0 && !rx_ev) |-> !tmr_fire); // R8
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_vec,
    input  logic [SRC_W-1:0] clr_vec,
    input  logic             rearm,
    input  logic             en_wr,
    input  irq_en_t          en_wdata,
    output logic [SRC_W-1:0] raw_q,
    output irq_en_t          en_q,
    output logic             irq_o
);
    logic [SRC_W-1:0] raw_d;
    irq_en_t          en_d;

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (SRC_MASK[i]) begin : g_live
            if (i == BIT_RX_RDY) begin : g_rearm
                always_comb raw_d[i] = set_vec[i] || (raw_q[i] && !clr_vec[i])
                                       || (rearm && !clr_vec[i]);
            end else begin : g_plain
                always_comb raw_d[i] = set_vec[i] || (raw_q[i] && !clr_vec[i]);
            end
        end else begin : g_dead
            always_comb raw_d[i] = 1'b0;
        end
    end

    always_comb begin
        en_d = en_q;
        if (en_wr) en_d = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= raw_d;
            en_q  <= en_d;
        end
    end

    assign irq_o = (|(raw_q & en_q.src)) && en_q.port && en_q.glb;

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q.port && en_q.glb)); // R5
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[BIT_TX_DONE] && clr_vec[BIT_TX_DONE]) |=> raw_q[BIT_TX_DONE]); // R4
    AST_W1C_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[BIT_TX_EMPTY] && !set_vec[BIT_TX_EMPTY]) |=> !raw_q[BIT_TX_EMPTY]); // R3
    AST_MULTI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[BIT_RX_MULTI] |=> raw_q[BIT_RX_MULTI]); // R7
endmodule

// File: rtl/mac_irq_hub.sv
module mac_irq_hub
    import mac_irq_pkg::*;
#(
    parameter int                PCNT_W       = 8,
    parameter int                TMR_W        = 16,
    parameter logic [THR_W-1:0]  COAL_THR_RST = 8'd8,
    parameter logic [TMR_W-1:0]  COAL_TMO_RST = 16'h0074
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_rx_frame,
    input  logic        ev_tx_done,
    input  logic        ev_tx_empty,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [TMR_W-1:0] tmo;
    } coal_cfg_t;

    coal_cfg_t        cfg_d, cfg_q;
    reg_sel_e         sel;
    logic             wr_status, wr_enable, wr_coal;
    logic [SRC_W-1:0] set_vec, clr_vec, raw;
    logic             multi_fire, pend_nz;
    irq_en_t          en_wdata, en;
    logic             unused_wdata;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_status = bus_wr && (sel == SEL_STATUS);
    assign wr_enable = bus_wr && (sel == SEL_ENABLE);
    assign wr_coal   = bus_wr && (sel == SEL_COALESCE);

    assign clr_vec   = wr_status ? bus_wdata[SRC_W-1:0] : '0;
    assign en_wdata  = '{src:  bus_wdata[SRC_W-1:0],
                         port: bus_wdata[EN_PORT_BIT],
                         glb:  bus_wdata[EN_GLB_BIT]};
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        set_vec               = '0;
        set_vec[BIT_RX_RDY]   = ev_rx_frame;
        set_vec[BIT_TX_DONE]  = ev_tx_done;
        set_vec[BIT_TX_EMPTY] = ev_tx_empty;
        set_vec[BIT_RX_MULTI] = multi_fire;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_coal) begin
            cfg_d.thr = bus_wdata[THR_LSB +: THR_W];
            cfg_d.tmo = bus_wdata[TMR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{thr: COAL_THR_RST, tmo: COAL_TMO_RST};
        else        cfg_q <= cfg_d;
    end

    mac_irq_coalesce #(.PCNT_W(PCNT_W), .TMR_W(TMR_W)) coal_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_ev      (ev_rx_frame),
        .rx_ack     (clr_vec[BIT_RX_RDY]),
        .thr        (cfg_q.thr),
        .tmo        (cfg_q.tmo),
        .multi_fire (multi_fire),
        .pend_nz    (pend_nz)
    );

    mac_irq_status stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rearm    (pend_nz),
        .en_wr    (wr_enable),
        .en_wdata (en_wdata),
        .raw_q    (raw),
        .en_q     (en),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS:   bus_rdata[SRC_W-1:0] = raw;
            SEL_ENABLE: begin
                bus_rdata[SRC_W-1:0]   = en.src;
                bus_rdata[EN_PORT_BIT] = en.port;
                bus_rdata[EN_GLB_BIT]  = en.glb;
            end
            SEL_COALESCE: begin
                bus_rdata[THR_LSB +: THR_W] = cfg_q.thr;
                bus_rdata[TMR_W-1:0]        = cfg_q.tmo;
            end
            default:      bus_rdata = '0;
        endcase
    end

    AST_UNUSED_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0)); // R9
    AST_ACK_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[BIT_RX_RDY] && !ev_rx_frame) |=> !raw[BIT_RX_RDY]); // R6
endmodule

// File: tb/mac_irq_hub_tb_top.sv
module mac_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx_frame = 1'b0, ev_tx_done = 1'b0, ev_tx_empty = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    mac_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .ev_rx_frame(ev_rx_frame), .ev_tx_done(ev_tx_done),
        .ev_tx_empty(ev_tx_empty), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // [18] write, [17:10] clear mask, [9] tx_done, [8] tx_empty, [7:0] expected status
    localparam logic [18:0] VEC [0:7] = '{
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h02},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h42},
        {1'b1, 8'h02, 1'b0, 1'b0, 8'h40},
        {1'b1, 8'h02, 1'b1, 1'b0, 8'h42},
        {1'b1, 8'h00, 1'b0, 1'b0, 8'h42},
        {1'b1, 8'hFF, 1'b0, 1'b0, 8'h00},
        {1'b1, 8'h40, 1'b1, 1'b1, 8'h42},
        {1'b1, 8'h42, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rx_pulse();
        ev_rx_frame = 1'b1;
        cyc();
        ev_rx_frame = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) wr(2'd0, 32'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd0, v); check("R1 status reset", v, 32'h0);
        rd(2'd1, v); check("R1 enable reset", v, 32'h0);
        rd(2'd2, v); check("R1 coalesce reset", v, 32'h0800_0074);
        check("R1 irq reset", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            bus_wr = VEC[i][18]; bus_addr = 2'd0; bus_wdata = {24'h0, VEC[i][17:10]};
            ev_tx_done = VEC[i][9]; ev_tx_empty = VEC[i][8];
            cyc();
            bus_wr = 1'b0; bus_wdata = '0; ev_tx_done = 1'b0; ev_tx_empty = 1'b0;
            rd(2'd0, v);
            check($sformatf("R2 R3 R4 vector %0d", i), v, {24'h0, VEC[i][7:0]});
        end

        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R9 enable readback", v, 32'h000C_00FF);
        wr(2'd2, 32'hFFAB_1234); rd(2'd2, v); check("R9 coalesce readback", v, 32'hFF00_1234);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R9 unused address", v, 32'h0);

        // R5: line gating
        wr(2'd1, 32'h0);
        ev_tx_done = 1'b1; cyc(); ev_tx_done = 1'b0;
        wr(2'd1, 32'h0000_0002); check("R5 source only", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h0004_0002); check("R5 no global", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h0008_0002); check("R5 no port", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h000C_0040); check("R5 other source", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h000C_0002); check("R5 all enabled", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h02);        check("R5 cleared", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h0);

        // threshold 3, timeout 5
        wr(2'd2, 32'h0300_0005);

        // R8: acked before expiry, no coalesced event
        rx_pulse(); rd(2'd0, v); check("R2 rx ready set", v, 32'h01);
        wr(2'd0, 32'h01);
        repeat (10) cyc();
        rd(2'd0, v); check("R8 acked no fire", v, 32'h0);

        // R6: ready bit drops then returns while backlog remains
        rx_pulse(); rx_pulse();
        wr(2'd0, 32'h01); rd(2'd0, v); check("R6 drop after ack", v & 32'h1, 32'h0);
        cyc();            rd(2'd0, v); check("R6 returns", v & 32'h1, 32'h1);
        wr(2'd0, 32'h01);
        repeat (10) cyc();
        rd(2'd0, v); check("R6 backlog drained", v, 32'h0);

        // R8: timeout fires T+1 edges after the frame
        rx_pulse();
        repeat (5) cyc(); rd(2'd0, v); check("R8 before expiry", v & 32'h80, 32'h0);
        cyc();            rd(2'd0, v); check("R8 at expiry", v & 32'h80, 32'h80);
        wr(2'd0, 32'hFF);
        rd(2'd0, v); check("R3 clear all", v, 32'h0);

        // R8: restart on a new frame
        rx_pulse(); repeat (3) cyc(); rx_pulse();
        repeat (5) cyc(); rd(2'd0, v); check("R8 restarted early", v & 32'h80, 32'h0);
        cyc();            rd(2'd0, v); check("R8 restarted fire", v & 32'h80, 32'h80);
        wr(2'd0, 32'h81); wr(2'd0, 32'h81);
        rd(2'd0, v); check("R6 two acks clear", v, 32'h0);

        // R7: count threshold
        rx_pulse(); rx_pulse(); rd(2'd0, v); check("R7 below threshold", v & 32'h80, 32'h0);
        rx_pulse();             rd(2'd0, v); check("R7 at threshold", v & 32'h80, 32'h80);
        wr(2'd0, 32'h80); drain();
        rd(2'd0, v); check("R7 drained", v, 32'h0);

        // R7: threshold zero disables the count trigger
        wr(2'd2, 32'h0000_0005);
        rx_pulse(); rx_pulse(); rx_pulse();
        rd(2'd0, v); check("R7 threshold zero", v & 32'h80, 32'h0);
        drain();
        rd(2'd0, v); check("R2 upper bits zero", v, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule